// File: doc/BRIEF.md
# Dual-law serial clock divider

This block derives a serial interface clock from the module clock for an SPI master's shift engine. A single control word carries two divisor fields and a law-select bit. With the linear law, each half period of the serial clock lasts (linear field + 1) module clock cycles. With the power-of-two law, each half period lasts 2^(exponent − 1) cycles, and exponent 0 gives the same half period as exponent 1. The linear law reaches half periods of up to 256 cycles. Slower rates need the power-of-two law.

The transfer engine raises an enable for the length of a transfer. While the enable is low, the serial clock rests at the idle level given on an input pin, and the divider loads any control word written earlier. While the enable is high, the clock toggles once every half period. Each edge that leaves the idle level comes with a one-cycle sample strobe. Each edge that returns to idle comes with a one-cycle shift strobe. Because the configuration is frozen during a transfer, a period is never cut short or stretched by a write.

Top module: `spi_sclk_div`

## Requirements
- R1: After reset, sclk_o is 0, both strobes are 0, and the active setting is the power-of-two law with exponent 0, so the first edge follows one enabled cycle.
- R2: The control word places the law select at bit 12 (1 = linear, 0 = power-of-two), the exponent at bits 11:8 and the linear field at bits 7:0.
- R3: In linear law, every half period of sclk_o lasts exactly (bits 7:0 + 1) module clock cycles, from 1 to 256.
- R4: In power-of-two law, every half period lasts 2^(e−1) cycles for exponent e ≥ 1, and 1 cycle for e = 0.
- R5: The field that belongs to the law not selected has no effect on the period.
- R6: One cycle after the enable is seen low, sclk_o equals the idle-level input and both strobes are 0. This holds even when the enable is dropped in the middle of a half period.
- R7: The first edge after the enable rises comes exactly one half period after the first enabled clock edge. It leaves the idle level and comes with sample_stb_o high for that one cycle.
- R8: Each edge that returns sclk_o to the idle level comes with shift_stb_o high for one cycle. A strobe is high only in the cycle right after sclk_o toggles, and the two strobes are never high together.
- R9: The control word and the idle level are applied only while the enable is low. A write during a transfer takes effect after the enable next drops.
- R10: The high and low phases of sclk_o last the same number of module cycles (50% duty).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 13 | Control word: law select, exponent, linear field |
| idle_pol_i | input | 1 | Resting level of the serial clock |
| xfer_en_i | input | 1 | Transfer enable from the shift engine |
| sclk_o | output | 1 | Serial clock |
| sample_stb_o | output | 1 | One-cycle strobe on the leading (capture) edge |
| shift_stb_o | output | 1 | One-cycle strobe on the trailing (launch) edge |

## Verification
The assertions check on every cycle that the clock returns to the idle level after the enable drops, that strobes line up one-for-one with toggles and never overlap, that a sample strobe marks the departure from idle, that the active setting stays frozen while enabled, and that the half-period counter never reaches the active half period. Only the bench scenarios can show the actual half-period lengths under each law and field value, that unused fields are ignored, the delay to the first edge, and that a write made during a transfer is held back until the next idle interval.

// File: rtl/spi_sclk_pkg.sv
// Package: shared types for the serial clock divider.
// Assumes nothing beyond a single clock domain.
package spi_sclk_pkg;

    // Division law selected by the top bit of the control word
    typedef enum logic {
        DIV_POW2 = 1'b0,
        DIV_LIN  = 1'b1
    } div_law_e;

endpackage

// File: rtl/sclk_cfg_stage.sv
// Module: sclk_cfg_stage
// Holds the written control word and decodes it into a half-period length.
// The decoded length and the idle level move into the active registers only
// while the transfer enable is low, so a running clock never changes rate.
// Assumes the caller keeps the enable high for the whole of a transfer.
module sclk_cfg_stage
    import spi_sclk_pkg::*;
#(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int CW     = 1 + EXP_W + LIN_W,
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CW-1:0]     wdata_i,
    input  logic              run_i,
    input  logic              pol_i,
    output logic [HALF_W-1:0] act_half_o,
    output logic              act_pol_o
);

    localparam int SEL_POS = CW - 1;

    logic [CW-1:0]     staged_q;
    logic [HALF_W-1:0] next_half;
    div_law_e          law;
    logic [EXP_W-1:0]  exp_f;
    logic [LIN_W-1:0]  lin_f;

    // Staging register: captures any write, at any time
    always_ff @(posedge clk) begin
        if (!rst_n) staged_q <= '0;
        else if (wr_i) staged_q <= wdata_i;
    end

    // Field split of the staged word
    always_comb begin
        law   = div_law_e'(staged_q[SEL_POS]);
        exp_f = staged_q[SEL_POS-1:LIN_W];
        lin_f = staged_q[LIN_W-1:0];
    end

    // Half-period decode for both laws
    always_comb begin
        if (law == DIV_LIN) begin
            next_half = HALF_W'(lin_f) + HALF_W'(1);
        end else if (exp_f == '0) begin
            next_half = HALF_W'(1);
        end else begin
            next_half = HALF_W'(1) << (exp_f - EXP_W'(1));
        end
    end

    // Active setting: reloaded only while the divider is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_half_o <= HALF_W'(1);
            act_pol_o  <= 1'b0;
        end else if (!run_i) begin
            act_half_o <= next_half;
            act_pol_o  <= pol_i;
        end
    end

endmodule

// File: rtl/sclk_half_timer.sv
// Module: sclk_half_timer
// Counts module cycles within the current half period and raises tick_o
// on the last cycle of each half. The count is held at zero while idle.
// Assumes half_i is at least 1 and stays constant while run_i is high.
module sclk_half_timer #(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              tick_o,
    output logic [HALF_W-1:0] cnt_o
);

    logic [HALF_W-1:0] cnt_q;

    // Last cycle of the current half period
    always_comb tick_o = run_i && (cnt_q == half_i - HALF_W'(1));

    // Cycle counter within a half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (tick_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + HALF_W'(1);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sclk_edge_gen.sv
// Module: sclk_edge_gen
// Toggles the serial clock on each tick and marks each toggle with the
// strobe that matches its direction relative to the idle level.
// Assumes tick_i is only ever high while run_i is high.
module sclk_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic act_pol_i,
    input  logic idle_pol_i,
    output logic sclk_o,
    output logic sample_o,
    output logic shift_o
);

    logic sclk_q;
    logic sample_q;
    logic shift_q;

    // Serial clock level and its edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            sample_q <= 1'b0;
            shift_q  <= 1'b0;
        end else if (!run_i) begin
            sclk_q   <= idle_pol_i;
            sample_q <= 1'b0;
            shift_q  <= 1'b0;
        end else if (tick_i) begin
            sclk_q   <= ~sclk_q;
            sample_q <= (sclk_q == act_pol_i);
            shift_q  <= (sclk_q != act_pol_i);
        end else begin
            sample_q <= 1'b0;
            shift_q  <= 1'b0;
        end
    end

    assign sclk_o   = sclk_q;
    assign sample_o = sample_q;
    assign shift_o  = shift_q;

endmodule

// File: rtl/spi_sclk_div.sv
// Module: spi_sclk_div (top)
// Serial clock divider with a linear and a power-of-two law chosen by one
// control bit. Connects the configuration stage, the half-period timer and
// the edge generator. Assumes a single module clock domain.
module spi_sclk_div #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_i,
    input  logic [EXP_W+LIN_W:0]     cfg_wdata_i,
    input  logic                     idle_pol_i,
    input  logic                     xfer_en_i,
    output logic                     sclk_o,
    output logic                     sample_stb_o,
    output logic                     shift_stb_o
);

    localparam int CW      = 1 + EXP_W + LIN_W;
    localparam int POW_MAX = (1 << EXP_W) - 1;
    localparam int HALF_W  = (POW_MAX > LIN_W + 1) ? POW_MAX : LIN_W + 1;

    logic [HALF_W-1:0] act_half;
    logic              act_pol;
    logic              tick;
    logic [HALF_W-1:0] cnt;

    sclk_cfg_stage #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .CW    (CW),
        .HALF_W(HALF_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr_i),
        .wdata_i   (cfg_wdata_i),
        .run_i     (xfer_en_i),
        .pol_i     (idle_pol_i),
        .act_half_o(act_half),
        .act_pol_o (act_pol)
    );

    sclk_half_timer #(
        .HALF_W(HALF_W)
    ) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (xfer_en_i),
        .half_i(act_half),
        .tick_o(tick),
        .cnt_o (cnt)
    );

    sclk_edge_gen edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (xfer_en_i),
        .tick_i    (tick),
        .act_pol_i (act_pol),
        .idle_pol_i(idle_pol_i),
        .sclk_o    (sclk_o),
        .sample_o  (sample_stb_o),
        .shift_o   (shift_stb_o)
    );

endmodule

// File: rtl/spi_sclk_div_chk.sv
// Module: spi_sclk_div_chk
// Cycle-level properties of the serial clock divider, bound into the top.
// Assumes the enable is held low while reset is asserted.
module spi_sclk_div_chk #(
    parameter int HALF_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_en_i,
    input logic              idle_pol_i,
    input logic              sclk_o,
    input logic              sample_stb_o,
    input logic              shift_stb_o,
    input logic [HALF_W-1:0] act_half,
    input logic              act_pol,
    input logic [HALF_W-1:0] cnt
);

    // R6: clock parks at the idle level one cycle after the enable is low
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(xfer_en_i)) |->
            (sclk_o == $past(idle_pol_i) && !sample_stb_o && !shift_stb_o));

    // R8: a strobe only follows a toggle
    p_strobe_on_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sample_stb_o || shift_stb_o)) |-> (sclk_o != $past(sclk_o)));

    // R8: a toggle while running always carries a strobe
    p_toggle_has_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(xfer_en_i) && sclk_o != $past(sclk_o)) |->
            (sample_stb_o || shift_stb_o));

    // R8: the two strobes never overlap
    p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb_o && shift_stb_o));

    // R7: a sample strobe marks a departure from idle
    p_sample_leaves_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> (sclk_o != act_pol));

    // R9: the active setting stays frozen while a transfer runs
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(xfer_en_i)) |-> ($stable(act_half) && $stable(act_pol)));

    // R10: the half-period count never reaches the active half length
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < act_half);

endmodule

bind spi_sclk_div spi_sclk_div_chk #(
    .HALF_W(HALF_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_en_i   (xfer_en_i),
    .idle_pol_i  (idle_pol_i),
    .sclk_o      (sclk_o),
    .sample_stb_o(sample_stb_o),
    .shift_stb_o (shift_stb_o),
    .act_half    (act_half),
    .act_pol     (act_pol),
    .cnt         (cnt)
);

// File: tb/spi_sclk_div_tb_top.sv
// Bench for spi_sclk_div: a vector table walked by one loop, then directed
// tests for reset, mid-transfer writes and an early enable drop.
module spi_sclk_div_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [12:0] cfg_wdata_i = '0;
    logic        idle_pol_i = 1'b0;
    logic        xfer_en_i = 1'b0;
    logic        sclk_o;
    logic        sample_stb_o;
    logic        shift_stb_o;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_sclk_div dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .idle_pol_i  (idle_pol_i),
        .xfer_en_i   (xfer_en_i),
        .sclk_o      (sclk_o),
        .sample_stb_o(sample_stb_o),
        .shift_stb_o (shift_stb_o)
    );

    // Vector: [31] idle level, [28:16] control word, [15:0] expected half period
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 2'b00, 13'h0000, 16'd1},     // all zero: pow2 e=0 (R4)
        {1'b0, 2'b00, 13'h0100, 16'd1},     // pow2 e=1 (R4)
        {1'b0, 2'b00, 13'h0200, 16'd2},     // pow2 e=2 (R4)
        {1'b1, 2'b00, 13'h0500, 16'd16},    // pow2 e=5, idle high (R4)
        {1'b0, 2'b00, 13'h0A00, 16'd512},   // pow2 e=10 (R4)
        {1'b0, 2'b00, 13'h0A7F, 16'd512},   // linear field ignored (R5)
        {1'b0, 2'b00, 13'h0F00, 16'd16384}, // pow2 e=15 (R4)
        {1'b0, 2'b00, 13'h1000, 16'd1},     // linear 0 (R3)
        {1'b1, 2'b00, 13'h1003, 16'd4},     // linear 3, idle high (R3)
        {1'b0, 2'b00, 13'h10FF, 16'd256},   // linear max (R3)
        {1'b0, 2'b00, 13'h1F05, 16'd6},     // exponent ignored (R5)
        {1'b1, 2'b00, 13'h1C10, 16'd17}     // exponent ignored, idle high (R5)
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Counts falling edges of clk until sclk_o reaches the given level
    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sclk_o != lvl && n < 40000);
    endtask

    task automatic write_cfg(input logic [12:0] w);
        @(negedge clk);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = w;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(sclk_o == 1'b0 && !sample_stb_o && !shift_stb_o, "R1 reset outputs",
            {sclk_o, sample_stb_o, shift_stb_o}, 0);
        // R1: default setting gives a one-cycle half period
        xfer_en_i = 1'b1;
        wait_level(1'b1, n);
        chk(n == 1, "R1 default half", n, 1);
        @(negedge clk);
        xfer_en_i = 1'b0;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic        pol;
            logic [12:0] w;
            int          h;
            pol = VEC[i][31];
            w   = VEC[i][28:16];
            h   = int'(VEC[i][15:0]);
            write_cfg(w);
            idle_pol_i = pol;
            repeat (2) @(negedge clk);
            xfer_en_i = 1'b1;
            wait_level(~pol, n);
            chk(n == h, w[12] ? "R3 first half" : "R4 first half", n, h);
            chk(sample_stb_o && !shift_stb_o, "R7 sample on leading edge",
                {sample_stb_o, shift_stb_o}, 2);
            wait_level(pol, n);
            chk(n == h, "R10 second half", n, h);
            chk(shift_stb_o && !sample_stb_o, "R8 shift on trailing edge",
                {sample_stb_o, shift_stb_o}, 1);
            @(negedge clk);
            xfer_en_i = 1'b0;
            @(negedge clk);
            chk(sclk_o == pol && !sample_stb_o && !shift_stb_o, "R6 idle after disable",
                sclk_o, pol);
        end

        // R9: a write during a transfer is deferred until idle
        write_cfg(13'h0200);
        idle_pol_i = 1'b0;
        repeat (2) @(negedge clk);
        xfer_en_i = 1'b1;
        wait_level(1'b1, n);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = 13'h1007;
        idle_pol_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        chk(n == 2, "R9 rate held during transfer", n, 2);
        wait_level(1'b0, n);
        chk(n == 2, "R9 low level held during transfer", n, 2);
        xfer_en_i = 1'b0;
        @(negedge clk);
        chk(sclk_o == 1'b1, "R9 new idle level after disable", sclk_o, 1);
        @(negedge clk);
        xfer_en_i = 1'b1;
        wait_level(1'b0, n);
        chk(n == 8, "R9 new rate after idle", n, 8);

        // R6: dropping the enable mid-half returns to idle at once
        @(negedge clk);
        @(negedge clk);
        xfer_en_i = 1'b0;
        @(negedge clk);
        chk(sclk_o == 1'b1 && !sample_stb_o && !shift_stb_o, "R6 early drop",
            sclk_o, 1);
        repeat (3) @(negedge clk);
        chk(sclk_o == 1'b1 && !sample_stb_o && !shift_stb_o, "R6 stays idle",
            sclk_o, 1);

        // R2/R5: select bit alone flips the law for identical fields
        write_cfg(13'h0303);
        idle_pol_i = 1'b0;
        repeat (2) @(negedge clk);
        xfer_en_i = 1'b1;
        wait_level(1'b1, n);
        chk(n == 4, "R2 bit 12 clear uses exponent", n, 4);
        @(negedge clk);
        xfer_en_i = 1'b0;
        write_cfg(13'h1303);
        repeat (2) @(negedge clk);
        xfer_en_i = 1'b1;
        wait_level(1'b1, n);
        chk(n == 4, "R2 bit 12 set uses linear", n, 4);
        @(negedge clk);
        xfer_en_i = 1'b0;
        write_cfg(13'h1305);
        repeat (2) @(negedge clk);
        xfer_en_i = 1'b1;
        wait_level(1'b1, n);
        chk(n == 6, "R2 linear field at bits 7:0", n, 6);
        @(negedge clk);
        xfer_en_i = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule